// File: doc/BRIEF.md
# Unified Forward/Inverse Modular Butterfly

This block is the arithmetic core of a radix-2 number theoretic transform engine. Each cycle it takes two coefficients, a twiddle factor and a direction bit. It returns two coefficients reduced modulo a prime `Q`. With the direction bit low it performs the decimation-in-time forward step. With the bit high it performs the decimation-in-frequency inverse step. Both directions run through one Montgomery multiplier. The direction bit only decides which operand reaches the multiplier and how its product is combined afterwards, so an inverse-capable engine needs no more multipliers than a forward-only one.

The twiddle input is taken in Montgomery form: the value the engine stores is the true twiddle times R = 2^W mod Q, where W is the coefficient width. The multiplier therefore yields the true product directly, and no conversion step is needed. Operands are fully reduced (below `Q`) on entry and on exit.

The pipeline accepts a new operand set on every clock. A valid flag and the direction bit travel with the data, so consecutive operand sets may use different directions and no flush is needed. Results appear a fixed number of cycles after the inputs are sampled: 5 + `EXTRA_DELAY`.

Top module: `ntt_bfly_unified`

## Requirements
- R1: With `in_inverse` = 0, the outputs are x = (a + t) mod Q and y = (a − t) mod Q, where t = b·w·R⁻¹ mod Q and R = 2^W.
- R2: With `in_inverse` = 1, the outputs are x = (a + b) mod Q and y = (a − b)·w·R⁻¹ mod Q.
- R3: Whenever `out_valid` is high, both `out_x` and `out_y` are strictly below Q.
- R4: One operand set is accepted per cycle. When inputs are sampled at a rising edge with `in_valid` high, `out_valid` is high with their result after exactly 5 + `EXTRA_DELAY` further rising edges, counting the sampling edge as the first. Results leave in the order the operand sets were accepted.
- R5: The direction bit may change on every cycle. Each result follows the direction given with its own operand set, whatever the neighbouring sets used.
- R6: While `rst` is high at a rising edge, `out_valid` is low after that edge.
- R7: Boundary operands (0, 1, Q−2, Q−1 for a, b and w) give correctly wrapped results in both directions, including for Q close to 2^W.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low 5 + `EXTRA_DELAY` edges later. It does not alter the results of the operand sets around it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set present this cycle |
| in_inverse | input | 1 | 0 = forward step, 1 = inverse step |
| in_a | input | W | First coefficient, below Q |
| in_b | input | W | Second coefficient, below Q |
| in_tw | input | W | Twiddle factor in Montgomery form, below Q |
| out_valid | output | 1 | Result present this cycle |
| out_x | output | W | First result coefficient |
| out_y | output | W | Second result coefficient |

## Verification
The two directions share one multiplier and one pipeline, so a forward operand set and an inverse operand set are in flight in neighbouring stages on almost every cycle. The sweep provokes this by toggling the direction bit on every accepted set and by inserting idle cycles between sets. Each result is then judged against a value the bench computes by modular exponentiation (for R⁻¹) and plain remainder arithmetic. The bench also checks on every cycle that `out_valid` matches the valid flag given 5 cycles earlier, so a set that inherits its neighbour's direction or slot shows up as a mismatch.

// File: rtl/ntt_bfly_unified.sv
module ntt_bfly_unified #(
  parameter int W = 32,
  parameter logic [W-1:0] Q = 32'd4294967291,
  parameter int EXTRA_DELAY = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_inverse,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_tw,
  output logic         out_valid,
  output logic [W-1:0] out_x,
  output logic [W-1:0] out_y
);

  function automatic logic [W-1:0] neg_inv(input logic [W-1:0] q);
    logic [W-1:0] v;
    v = 1;
    for (int i = 0; i < 7; i++) v = v * (W'(2) - q * v);
    return -v;
  endfunction

  localparam logic [W-1:0] QNEG = neg_inv(Q);

  function automatic logic [W-1:0] mod_add(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return (s >= {1'b0, Q}) ? W'(s - {1'b0, Q}) : W'(s);
  endfunction

  function automatic logic [W-1:0] mod_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] d;
    d = {1'b0, x} - {1'b0, y};
    return d[W] ? W'(d + {1'b0, Q}) : W'(d);
  endfunction

  logic           s1_v, s2_v, s3_v, s4_v, s5_v;
  logic           s1_inv, s2_inv, s3_inv, s4_inv;
  logic [W-1:0]   s1_a, s2_a, s3_a, s4_a;
  logic [W-1:0]   s1_sum, s2_sum, s3_sum, s4_sum;
  logic [W-1:0]   s1_mul, s1_tw;
  logic [2*W-1:0] s2_t, s3_t;
  logic [W-1:0]   s3_m;
  logic [W-1:0]   s4_p;
  logic [W-1:0]   s5_x, s5_y;

  logic [2*W-1:0] mq;
  logic [2*W:0]   acc;
  logic [W:0]     u;
  logic [W-1:0]   p_red;

  assign mq    = {{W{1'b0}}, s3_m} * {{W{1'b0}}, Q};
  assign acc   = {1'b0, s3_t} + {1'b0, mq};
  assign u     = (W+1)'(acc >> W);
  assign p_red = (u >= {1'b0, Q}) ? W'(u - {1'b0, Q}) : W'(u);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
      s4_v <= 1'b0;
      s5_v <= 1'b0;
    end else begin
      s1_v <= in_valid;
      s2_v <= s1_v;
      s3_v <= s2_v;
      s4_v <= s3_v;
      s5_v <= s4_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_inv <= in_inverse;
    s1_a   <= in_a;
    s1_sum <= mod_add(in_a, in_b);
    s1_mul <= in_inverse ? mod_sub(in_a, in_b) : in_b;
    s1_tw  <= in_tw;

    s2_inv <= s1_inv;
    s2_a   <= s1_a;
    s2_sum <= s1_sum;
    s2_t   <= {{W{1'b0}}, s1_mul} * {{W{1'b0}}, s1_tw};

    s3_inv <= s2_inv;
    s3_a   <= s2_a;
    s3_sum <= s2_sum;
    s3_t   <= s2_t;
    s3_m   <= s2_t[W-1:0] * QNEG;

    s4_inv <= s3_inv;
    s4_a   <= s3_a;
    s4_sum <= s3_sum;
    s4_p   <= p_red;

    s5_x   <= s4_inv ? s4_sum : mod_add(s4_a, s4_p);
    s5_y   <= s4_inv ? s4_p   : mod_sub(s4_a, s4_p);
  end

  generate
    if (EXTRA_DELAY == 0) begin : g_direct
      assign out_valid = s5_v;
      assign out_x     = s5_x;
      assign out_y     = s5_y;
    end else begin : g_delay
      logic         dv [EXTRA_DELAY];
      logic [W-1:0] dx [EXTRA_DELAY];
      logic [W-1:0] dy [EXTRA_DELAY];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < EXTRA_DELAY; i++) dv[i] <= 1'b0;
        end else begin
          dv[0] <= s5_v;
          for (int i = 1; i < EXTRA_DELAY; i++) dv[i] <= dv[i-1];
        end
      end
      always_ff @(posedge clk) begin
        dx[0] <= s5_x;
        dy[0] <= s5_y;
        for (int i = 1; i < EXTRA_DELAY; i++) begin
          dx[i] <= dx[i-1];
          dy[i] <= dy[i-1];
        end
      end
      assign out_valid = dv[EXTRA_DELAY-1];
      assign out_x     = dx[EXTRA_DELAY-1];
      assign out_y     = dy[EXTRA_DELAY-1];
    end
  endgenerate

endmodule

// File: rtl/ntt_bfly_unified_chk.sv
module ntt_bfly_unified_chk #(
  parameter int W = 32,
  parameter logic [W-1:0] Q = 32'd4294967291,
  parameter int EXTRA_DELAY = 0
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_inverse,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic [W-1:0] out_x,
  input logic [W-1:0] out_y
);
  localparam int LAT = 5 + EXTRA_DELAY;

  logic         h_v   [LAT];
  logic         h_inv [LAT];
  logic [W-1:0] h_a   [LAT];
  logic [W-1:0] h_b   [LAT];
  logic         rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      for (int i = 0; i < LAT; i++) h_v[i] <= 1'b0;
    end else begin
      h_v[0] <= in_valid;
      for (int i = 1; i < LAT; i++) h_v[i] <= h_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    h_inv[0] <= in_inverse;
    h_a[0]   <= in_a;
    h_b[0]   <= in_b;
    for (int i = 1; i < LAT; i++) begin
      h_inv[i] <= h_inv[i-1];
      h_a[i]   <= h_a[i-1];
      h_b[i]   <= h_b[i-1];
    end
  end

  function automatic logic [W:0] rem2(input logic [W:0] x, input logic [W:0] y);
    return (x + y) % {1'b0, Q};
  endfunction

  assert_valid_latency_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid == h_v[LAT-1]) else $error("out_valid does not follow in_valid by LAT");

  assert_out_reduced_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_x < Q) && (out_y < Q)) else $error("unreduced output");

  assert_inverse_sum_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && h_inv[LAT-1]) |->
      ({1'b0, out_x} == rem2({1'b0, h_a[LAT-1]}, {1'b0, h_b[LAT-1]})))
    else $error("inverse sum output wrong");

  assert_forward_pair_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !h_inv[LAT-1]) |->
      (rem2({1'b0, out_x}, {1'b0, out_y}) == rem2({1'b0, h_a[LAT-1]}, {1'b0, h_a[LAT-1]})))
    else $error("forward outputs do not sum to twice a");

  always @(negedge clk) begin
    if (rst_d) begin
      assert_reset_quiet_R6: assert (!out_valid) else $error("out_valid high under reset");
    end
  end
endmodule

bind ntt_bfly_unified ntt_bfly_unified_chk #(.W(W), .Q(Q), .EXTRA_DELAY(EXTRA_DELAY)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_inverse(in_inverse),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
);

// File: tb/tb_ntt_bfly_unified.sv
module tb_ntt_bfly_unified;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 5;
  localparam longint unsigned QS = 13;
  localparam longint unsigned QW = 64'd4294967291;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       s_v = 1'b0, s_inv = 1'b0;
  logic [7:0] s_a = '0, s_b = '0, s_w = '0;
  logic       s_ov;
  logic [7:0] s_x, s_y;

  logic        w_v = 1'b0, w_inv = 1'b0;
  logic [31:0] w_a = '0, w_b = '0, w_w = '0;
  logic        w_ov;
  logic [31:0] w_x, w_y;

  ntt_bfly_unified #(.W(8), .Q(8'd13), .EXTRA_DELAY(0)) dut (
    .clk(clk), .rst(rst), .in_valid(s_v), .in_inverse(s_inv),
    .in_a(s_a), .in_b(s_b), .in_tw(s_w),
    .out_valid(s_ov), .out_x(s_x), .out_y(s_y));

  ntt_bfly_unified #(.W(32), .Q(32'd4294967291), .EXTRA_DELAY(0)) dut_wide (
    .clk(clk), .rst(rst), .in_valid(w_v), .in_inverse(w_inv),
    .in_a(w_a), .in_b(w_b), .in_tw(w_w),
    .out_valid(w_ov), .out_x(w_x), .out_y(w_y));

  int nchk = 0, nfail = 0;
  int cyc = 0;
  bit mon_on = 0, done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint unsigned sx [8192], sy [8192], wx [4096], wy [4096];
  string stag [8192], wtag [4096];
  bit svh [16384], wvh [16384];
  int sn = 0, sr = 0, wn = 0, wr = 0;
  longint unsigned rinv_s, rinv_w;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint unsigned powmod(input longint unsigned bs,
      input longint unsigned e, input longint unsigned q);
    longint unsigned r = 1, x = bs % q, k = e;
    while (k != 0) begin
      if (k[0]) r = (r * x) % q;
      x = (x * x) % q;
      k = k >> 1;
    end
    return r;
  endfunction

  function automatic void model(input bit inv, input longint unsigned a, input longint unsigned b,
      input longint unsigned w, input longint unsigned q, input longint unsigned ri,
      output longint unsigned x, output longint unsigned y);
    longint unsigned t;
    if (!inv) begin
      t = (((b * w) % q) * ri) % q;
      x = (a + t) % q;
      y = (a + q - t) % q;
    end else begin
      t = (a + q - b) % q;
      x = (a + b) % q;
      y = (((t * w) % q) * ri) % q;
    end
  endfunction

  task automatic drive_s(input bit v, input bit inv, input int a, input int b, input int w,
                         input string tag);
    longint unsigned x, y;
    @(negedge clk);
    s_v = v; s_inv = inv; s_a = 8'(a); s_b = 8'(b); s_w = 8'(w);
    svh[cyc] = v;
    if (v) begin
      model(inv, longint'(a), longint'(b), longint'(w), QS, rinv_s, x, y);
      sx[sn] = x; sy[sn] = y; stag[sn] = tag; sn++;
    end
  endtask

  task automatic drive_w(input bit v, input bit inv, input longint unsigned a,
                         input longint unsigned b, input longint unsigned w, input string tag);
    longint unsigned x, y;
    @(negedge clk);
    w_v = v; w_inv = inv; w_a = 32'(a); w_b = 32'(b); w_w = 32'(w);
    wvh[cyc] = v;
    if (v) begin
      model(inv, a, b, w, QW, rinv_w, x, y);
      wx[wn] = x; wy[wn] = y; wtag[wn] = tag; wn++;
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && !done && cyc >= LAT) begin
      chk(s_ov == svh[cyc-LAT], svh[cyc-LAT] ? "R4" : "R8", "narrow out_valid",
          longint'(s_ov), longint'(svh[cyc-LAT]));
      if (s_ov && svh[cyc-LAT]) begin
        chk(longint'(s_x) == sx[sr] && longint'(s_y) == sy[sr], stag[sr], "narrow x,y",
            (longint'(s_x) << 16) | longint'(s_y), (sx[sr] << 16) | sy[sr]);
        chk(longint'(s_x) < QS && longint'(s_y) < QS, "R3", "narrow range",
            longint'(s_x) > longint'(s_y) ? longint'(s_x) : longint'(s_y), QS - 1);
        sr++;
      end
      chk(w_ov == wvh[cyc-LAT], wvh[cyc-LAT] ? "R4" : "R8", "wide out_valid",
          longint'(w_ov), longint'(wvh[cyc-LAT]));
      if (w_ov && wvh[cyc-LAT]) begin
        chk(longint'(w_x) == wx[wr], wtag[wr], "wide x", longint'(w_x), wx[wr]);
        chk(longint'(w_y) == wy[wr], wtag[wr], "wide y", longint'(w_y), wy[wr]);
        chk(longint'(w_x) < QW && longint'(w_y) < QW, "R3", "wide range",
            longint'(w_x), QW - 1);
        wr++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    longint unsigned corner [4];
    int k = 0;
    rinv_s = powmod(256 % QS, QS - 2, QS);
    rinv_w = powmod((64'd1 << 32) % QW, QW - 2, QW);
    corner[0] = 0; corner[1] = 1; corner[2] = QW - 2; corner[3] = QW - 1;

    s_v = 1'b1; w_v = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!s_ov, "R6", "narrow out_valid in reset", longint'(s_ov), 0);
    chk(!w_ov, "R6", "wide out_valid in reset", longint'(w_ov), 0);
    rst = 1'b0; s_v = 1'b0; w_v = 1'b0;
    mon_on = 1;

    for (int a = 0; a < 13; a++)
      for (int b = 0; b < 13; b++)
        for (int w = 0; w < 13; w++)
          for (int m = 0; m < 2; m++) begin
            drive_s(1'b1, m[0], a, b, w, m == 0 ? "R1" : "R2");
            k++;
            if (k % 7 == 6) drive_s(1'b0, 1'b0, 0, 0, 0, "R8");
          end
    drive_s(1'b0, 1'b0, 0, 0, 0, "R8");

    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int t = 0; t < 4; t++)
          for (int m = 0; m < 2; m++)
            drive_w(1'b1, m[0], corner[i], corner[j], corner[t], "R7");

    for (int n = 0; n < 1500; n++) begin
      drive_w(1'b1, 1'($urandom % 2), longint'($urandom) % QW,
              longint'($urandom) % QW, longint'($urandom) % QW, "R5");
      if ($urandom % 5 == 0) drive_w(1'b0, 1'b0, 0, 0, 0, "R8");
    end
    drive_w(1'b0, 1'b0, 0, 0, 0, "R8");

    repeat (LAT + 4) @(negedge clk);
    chk(sr == sn, "R4", "narrow results delivered", longint'(sr), longint'(sn));
    chk(wr == wn, "R4", "wide results delivered", longint'(wr), longint'(wn));
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule